// File: doc/BRIEF.md
# SPI PSRAM Read Cache Controller

This block connects a byte-wide memory request port to a serial pseudo-static RAM on a single-lane SPI bus. Reads are answered from a small direct-mapped cache of aligned lines. A read that misses fetches the whole line with fast-read bursts, then answers from the cache. Writes go straight to the device, one byte per frame. If the written byte's line is resident, the cached copy is updated as well. The block suits workloads that load the device once and then mostly read from it.

The device must not keep chip select low for longer than a set time. The parameters `CS_MAX_NS`, `CLK_MHZ` and `HALF_CYC` give that limit and the SPI clock rate. From them the block computes how many bytes fit in one frame. When a line does not fit in one frame, the block splits the fill into several frames with ascending addresses. Lines are 16-byte aligned, so no frame ever crosses a 1 KB device page.

The controller is one state machine, with these states and transitions:
- After reset, `S_START` goes to `S_CSLO`.
- `S_CSLO` drops chip select, starts the first byte and goes to `S_XFER`.
- `S_XFER` runs the frame's bytes back to back. After the last byte it goes to `S_GAP`.
- `S_GAP` raises chip select and picks the next step:
  - reset-enable goes back to `S_CSLO` for the reset frame;
  - reset goes to `S_IDLE`;
  - an unfinished fill goes back to `S_CSLO`;
  - a finished fill goes to `S_LOAD`;
  - a write goes to `S_RESP`.
- `S_IDLE` handles requests:
  - a read hit goes to `S_LOAD`;
  - a read miss goes to `S_CSLO`;
  - a write goes to `S_CSLO`.
- `S_LOAD` captures the byte and goes to `S_PRESENT`.
- `S_PRESENT` goes to `S_RESP`.
- `S_RESP` raises ready for one cycle and goes back to `S_IDLE`.

Top module: `psram_read_cache`

## Requirements
- R1: After reset the block sends two single-byte frames, 0x66 and then 0x99, each in its own chip-select frame. It accepts no request and never raises `rsp_ready` until both have been sent. `rsp_ready` is never high while chip select is low.
- R2: SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sck` is low, most significant bit first. `spi_miso` is sampled on the rising edge of `spi_sck`.
- R3: A fill frame has this layout:
  - opcode 0x0B;
  - three address bytes, most significant byte first;
  - one dummy byte;
  - the data bytes, starting at the line base, which is the address with bits [3:0] cleared, plus the offset of the chunk.
- R4: A frame of N bytes keeps chip select low for 1+N*(16*HALF_CYC+1) clock cycles. N is the largest value for which that count stays at or below CS_MAX_NS*CLK_MHZ/1000. A line longer than N-5 bytes is filled in several frames at ascending addresses. The bench uses CLK_MHZ=50, HALF_CYC=1 and CS_MAX_NS=4500, which gives two 13-byte frames per 16-byte line and at most 225 low cycles.
- R5: No frame's data range crosses a 1 KB device page boundary.
- R6: A read hit sends no SPI frame. If the request is sampled in `S_IDLE` at clock edge k:
  - `rsp_rdata` holds the byte after edge k+1;
  - `rsp_ready` rises after edge k+2.
- R7: A read miss fills the line from the device, then returns the requested byte. Later reads anywhere in that line hit and return the device contents.
- R8: The cache is direct-mapped. Address bits [7:4] select the line and bits [23:8] are the tag. Two addresses with the same index and different tags evict each other.
- R9: A write sends one 5-byte frame: opcode 0x02, three address bytes most significant byte first, then the data byte, with no dummy byte. `rsp_ready` pulses after that frame ends.
- R10: A write to a resident line also updates the cached byte, so a later read hits and returns the new value. A write to a line that is not resident does not allocate it, so a later read misses.
- R11: `rsp_ready` is high for exactly one cycle per request. `rsp_rdata` keeps its value until the next read.
- R12: Reset clears every valid bit, so the first read of any line after a reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 24 | Byte address of the request, held until ready |
| req_rd | input | 1 | Read strobe, held until ready |
| req_wr | input | 1 | Write strobe, held until ready (read wins if both are high) |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Controller-to-device data |
| spi_miso | input | 1 | Device-to-controller data |

## Verification
The bench models the device bit by bit on the SPI pins and keeps its own reference copy of the valid bits and tags.
- Lines that straddle a chunk boundary are read back. A fill whose chunk offset or byte index is off by one would return shifted bytes.
- Aliasing addresses are read alternately. A design that compared too few tag bits would return stale data with no SPI traffic.
- The last line of a page is filled, and chip-select low time is measured on every frame. A wrong burst cap shows up as a frame that overstays the limit or has the wrong byte count.
- Writes are made to both resident and absent lines, and a second reset is applied. A design that skipped the cache update, allocated on a write, or kept valid bits through reset would return wrong data or show the wrong number of fill frames.

// File: rtl/psram_cache_pkg.sv
package psram_cache_pkg;

    localparam int ADDR_W   = 24;   // three address bytes on the wire
    localparam int HDR_READ = 5;    // opcode + 3 address + dummy
    localparam int LEN_WR   = 5;    // opcode + 3 address + data

    localparam logic [7:0] OP_RST_EN = 8'h66;
    localparam logic [7:0] OP_RST    = 8'h99;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_WRITE  = 8'h02;

    typedef enum logic [2:0] {
        S_START, S_CSLO, S_XFER, S_GAP, S_IDLE, S_LOAD, S_PRESENT, S_RESP
    } ctl_state_t;

    typedef enum logic [1:0] {
        K_RST_EN, K_RST, K_FILL, K_WRITE
    } frame_kind_t;

    // Bytes that fit in one frame: 1 select cycle plus (16*half+1) per byte.
    function automatic int frame_fit(input int cs_max_clks, input int half_cyc);
        return (cs_max_clks - 1) / (16 * half_cyc + 1);
    endfunction

endpackage

// File: rtl/psram_spi_shifter.sv
module psram_spi_shifter #(
    parameter int HALF_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);

    localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [7:0]      sh_q;
    logic [2:0]      bit_q;
    logic [HC_W-1:0] hc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sck     <= 1'b0;
            mosi    <= 1'b0;
            sh_q    <= '0;
            rx_byte <= '0;
            bit_q   <= '0;
            hc_q    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    sh_q  <= tx_byte;
                    mosi  <= tx_byte[7];
                    bit_q <= '0;
                    hc_q  <= '0;
                end
            end else if (hc_q == HC_W'(HALF_CYC - 1)) begin
                hc_q <= '0;
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                        mosi  <= sh_q[6];
                    end
                end
            end else begin
                hc_q <= hc_q + HC_W'(1);
            end
        end
    end

    // R2: the clock idles low outside a byte
    a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    // R2: data is steady while the clock is high
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sck) |-> $stable(mosi));

endmodule

// File: rtl/psram_line_store.sv
module psram_line_store
    import psram_cache_pkg::*;
#(
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             lk_addr,
    output logic                          lk_hit,
    output logic [7:0]                    lk_byte,
    input  logic                          wr_en,
    input  logic [$clog2(LINES)-1:0]      wr_idx,
    input  logic [$clog2(LINE_BYTES)-1:0] wr_off,
    input  logic [7:0]                    wr_byte,
    input  logic                          inv_en,
    input  logic [$clog2(LINES)-1:0]      inv_idx,
    input  logic                          set_en,
    input  logic [$clog2(LINES)-1:0]      set_idx,
    input  logic [ADDR_W-$clog2(LINES)-$clog2(LINE_BYTES)-1:0] set_tag
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [7:0]       data_q [LINES][LINE_BYTES];
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [LINES-1:0] val_q;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;

    assign lk_idx  = lk_addr[OFF_W +: IDX_W];
    assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_hit  = val_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_byte = data_q[lk_idx][lk_addr[OFF_W-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx][wr_off] <= wr_byte;
        if (set_en) tag_q[set_idx] <= set_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            if (inv_en) val_q[inv_idx] <= 1'b0;
            if (set_en) val_q[set_idx] <= 1'b1;
        end
    end

    // R7: a line being refilled is never marked valid in the same cycle
    a_r7_inv_set_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_en && set_en));

endmodule

// File: rtl/psram_read_cache.sv
module psram_read_cache
    import psram_cache_pkg::*;
#(
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 16,
    parameter int CLK_MHZ    = 50,
    parameter int HALF_CYC   = 1,
    parameter int CS_MAX_NS  = 8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] req_addr,
    input  logic        req_rd,
    input  logic        req_wr,
    input  logic [7:0]  req_wdata,
    output logic [7:0]  rsp_rdata,
    output logic        rsp_ready,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    localparam int OFF_W       = $clog2(LINE_BYTES);
    localparam int IDX_W       = $clog2(LINES);
    localparam int TAG_W       = ADDR_W - IDX_W - OFF_W;
    localparam int CS_MAX_CLKS = CS_MAX_NS * CLK_MHZ / 1000;
    localparam int FRAME_FIT   = frame_fit(CS_MAX_CLKS, HALF_CYC);
    localparam int BURST_FIT   = FRAME_FIT - HDR_READ;
    localparam int CHUNK       = (BURST_FIT < LINE_BYTES) ? BURST_FIT : LINE_BYTES;
    localparam int CNT_W       = $clog2(LINE_BYTES + HDR_READ + 1);
    localparam int CSC_W       = $clog2(CS_MAX_CLKS + 2);

    ctl_state_t  state_q, state_d;
    frame_kind_t kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [CNT_W-1:0]  bidx_q;
    logic [OFF_W:0]    fill_off_q;

    logic [OFF_W:0]    remain, chunk_len;
    logic [CNT_W-1:0]  frame_len, tx_idx;
    logic [ADDR_W-1:0] frame_addr;
    logic [7:0]        tx_byte, opcode;
    logic              fill_last, last_byte;

    logic       eng_start, eng_busy, eng_done;
    logic [7:0] eng_rx;

    logic              lk_hit;
    logic [7:0]        lk_byte;
    logic [ADDR_W-1:0] lk_addr;
    logic              st_wr_en, st_inv_en, st_set_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [OFF_W-1:0]  st_wr_off;
    logic [7:0]        st_wr_byte;

    // ---------------- frame shaping ----------------
    always_comb begin
        remain     = (OFF_W+1)'(LINE_BYTES) - fill_off_q;
        chunk_len  = (remain < (OFF_W+1)'(CHUNK)) ? remain : (OFF_W+1)'(CHUNK);
        fill_last  = (fill_off_q + chunk_len) == (OFF_W+1)'(LINE_BYTES);
        frame_addr = (kind_q == K_FILL) ? {addr_q[ADDR_W-1:OFF_W], fill_off_q[OFF_W-1:0]} : addr_q;
        unique case (kind_q)
            K_RST_EN: begin frame_len = CNT_W'(1);      opcode = OP_RST_EN; end
            K_RST:    begin frame_len = CNT_W'(1);      opcode = OP_RST;    end
            K_WRITE:  begin frame_len = CNT_W'(LEN_WR); opcode = OP_WRITE;  end
            K_FILL:   begin frame_len = CNT_W'(HDR_READ) + CNT_W'(chunk_len); opcode = OP_FREAD; end
        endcase
        tx_idx    = (state_q == S_CSLO) ? '0 : bidx_q + CNT_W'(1);
        last_byte = eng_done && (bidx_q == frame_len - CNT_W'(1));
        unique case (tx_idx)
            CNT_W'(0): tx_byte = opcode;
            CNT_W'(1): tx_byte = frame_addr[23:16];
            CNT_W'(2): tx_byte = frame_addr[15:8];
            CNT_W'(3): tx_byte = frame_addr[7:0];
            CNT_W'(4): tx_byte = (kind_q == K_WRITE) ? wdata_q : 8'h00;
            default:   tx_byte = 8'h00;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_START;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_START:   state_d = S_CSLO;
            S_CSLO:    state_d = S_XFER;
            S_XFER:    if (last_byte) state_d = S_GAP;
            S_GAP: begin
                unique case (kind_q)
                    K_RST_EN: state_d = S_CSLO;
                    K_RST:    state_d = S_IDLE;
                    K_FILL:   state_d = fill_last ? S_LOAD : S_CSLO;
                    K_WRITE:  state_d = S_RESP;
                endcase
            end
            S_IDLE: begin
                if (req_rd)      state_d = lk_hit ? S_LOAD : S_CSLO;
                else if (req_wr) state_d = S_CSLO;
            end
            S_LOAD:    state_d = S_PRESENT;
            S_PRESENT: state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= K_RST_EN;
            addr_q     <= '0;
            wdata_q    <= '0;
            bidx_q     <= '0;
            fill_off_q <= '0;
            rsp_rdata  <= '0;
        end else begin
            unique case (state_q)
                S_CSLO: bidx_q <= '0;
                S_XFER: if (eng_done && !last_byte) bidx_q <= bidx_q + CNT_W'(1);
                S_GAP: begin
                    if (kind_q == K_RST_EN) kind_q <= K_RST;
                    if (kind_q == K_FILL && !fill_last) fill_off_q <= fill_off_q + chunk_len;
                end
                S_IDLE: begin
                    if (req_rd) begin
                        addr_q <= req_addr;
                        if (!lk_hit) begin
                            kind_q     <= K_FILL;
                            fill_off_q <= '0;
                        end
                    end else if (req_wr) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        kind_q  <= K_WRITE;
                    end
                end
                S_LOAD: rsp_rdata <= lk_byte;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        spi_cs_n   = !(state_q == S_CSLO || state_q == S_XFER);
        rsp_ready  = (state_q == S_RESP);
        eng_start  = (state_q == S_CSLO) || (state_q == S_XFER && eng_done && !last_byte);
        lk_addr    = (state_q == S_IDLE) ? req_addr : addr_q;
        st_inv_en  = (state_q == S_IDLE) && req_rd && !lk_hit;
        st_set_en  = (state_q == S_GAP) && (kind_q == K_FILL) && fill_last;
        st_wr_en   = 1'b0;
        st_wr_idx  = addr_q[OFF_W +: IDX_W];
        st_wr_off  = fill_off_q[OFF_W-1:0] + OFF_W'(bidx_q - CNT_W'(HDR_READ));
        st_wr_byte = eng_rx;
        if (state_q == S_XFER && kind_q == K_FILL && eng_done && bidx_q >= CNT_W'(HDR_READ)) begin
            st_wr_en = 1'b1;
        end else if (state_q == S_IDLE && !req_rd && req_wr && lk_hit) begin
            st_wr_en   = 1'b1;
            st_wr_idx  = req_addr[OFF_W +: IDX_W];
            st_wr_off  = req_addr[OFF_W-1:0];
            st_wr_byte = req_wdata;
        end
    end

    psram_spi_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(tx_byte),
        .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
        .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
    );

    psram_line_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_byte(lk_byte),
        .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_off(st_wr_off), .wr_byte(st_wr_byte),
        .inv_en(st_inv_en), .inv_idx(req_addr[OFF_W +: IDX_W]),
        .set_en(st_set_en), .set_idx(addr_q[OFF_W +: IDX_W]), .set_tag(addr_q[ADDR_W-1 -: TAG_W])
    );

    // ---------------- assertions ----------------
    logic [CSC_W-1:0] cs_lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cs_lo_cnt <= '0;
        else if (spi_cs_n) cs_lo_cnt <= '0;
        else if (cs_lo_cnt != {CSC_W{1'b1}}) cs_lo_cnt <= cs_lo_cnt + CSC_W'(1);
    end

    // R4: select low time stays within the window
    a_r4_cs_window: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> (cs_lo_cnt < CSC_W'(CS_MAX_CLKS)));
    // R1: no completion while a frame is open
    a_r1_no_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !rsp_ready);
    // R11: ready is a single-cycle pulse
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);
    // R6: data is settled before ready rises
    a_r6_rdata_early: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> $stable(rsp_rdata));
    // R6: a hit completes three edges after acceptance
    a_r6_hit_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_rd && lk_hit) |-> ##3 rsp_ready);
    // R5: a fill frame stays inside one 1 KB page
    a_r5_page: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CSLO && kind_q == K_FILL) |->
        (frame_addr[23:10] == ((frame_addr + ADDR_W'(chunk_len) - ADDR_W'(1)) >> 10)));
    // R2: a byte is only started on an idle shifter
    a_r2_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

endmodule

// File: tb/psram_read_cache_tb.sv
module psram_read_cache_tb;

    localparam int CS_LIMIT    = 225;  // 4500 ns at 50 MHz
    localparam int FILL_FRAMES = 2;
    localparam int FILL_LEN    = 13;   // 5 header + 8 data

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_ready, cs_n, sck, mosi;
    logic        miso = 1'b0;

    always #10 clk = ~clk;

    psram_read_cache #(.CLK_MHZ(50), .HALF_CYC(1), .CS_MAX_NS(4500)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready),
        .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso)
    );

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // ---------------- device model and memory ----------------
    logic [7:0] dev_mem [int];
    logic [7:0] exp_mem [int];

    function automatic logic [7:0] pat(input int a);
        logic [23:0] x;
        x = a[23:0];
        return x[7:0] ^ x[15:8] ^ x[23:16] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] dev_rd(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : pat(a);
    endfunction
    function automatic logic [7:0] exp_rd(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : pat(a);
    endfunction

    int dev_bits, dev_nbytes, dev_addr;
    logic [7:0] dev_sh, dev_op;
    bit frame_open = 0;
    int fr_op[$], fr_addr[$], fr_n[$];

    always @(negedge cs_n) begin
        frame_open = 1; dev_bits = 0; dev_nbytes = 0; dev_addr = 0; dev_op = 0;
    end
    always @(posedge cs_n) if (frame_open) begin
        frame_open = 0;
        fr_op.push_back(int'(dev_op)); fr_addr.push_back(dev_addr); fr_n.push_back(dev_nbytes);
    end
    always @(posedge sck) if (!cs_n) begin
        dev_sh = {dev_sh[6:0], mosi};
        dev_bits++;
        if (dev_bits % 8 == 0) begin
            case (dev_nbytes)
                0: dev_op = dev_sh;
                1, 2, 3: dev_addr = (dev_addr << 8) | int'(dev_sh);
                4: if (dev_op == 8'h02) dev_mem[dev_addr] = dev_sh;
                default: ;
            endcase
            dev_nbytes++;
        end
    end
    always @(negedge sck) if (!cs_n && dev_op == 8'h0B && dev_bits >= 40) begin
        logic [7:0] b;
        b = dev_rd(dev_addr + (dev_bits - 40) / 8);
        miso = b[7 - ((dev_bits - 40) % 8)];
    end

    // ---------------- per-clock monitors ----------------
    int cs_run = 0, cs_max = 0, cyc = 0;
    int sck_bad = 0, mosi_bad = 0, ready_bad = 0, frame_ready_bad = 0;
    logic prev_sck = 0, prev_mosi = 0, prev_ready = 0;

    always @(posedge clk) begin
        if (cs_n) cs_run = 0;
        else begin cs_run++; if (cs_run > cs_max) cs_max = cs_run; end
    end
    always @(negedge clk) if (rst_n) begin
        if (cs_n && sck) sck_bad++;
        if (sck && prev_sck && mosi != prev_mosi) mosi_bad++;
        if (rsp_ready && prev_ready) ready_bad++;
        if (!cs_n && rsp_ready) frame_ready_bad++;
        prev_sck = sck; prev_mosi = mosi; prev_ready = rsp_ready;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog all actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    // ---------------- reference cache model ----------------
    bit ref_v [16];
    int ref_t [16];

    task automatic ref_clear();
        for (int i = 0; i < 16; i++) ref_v[i] = 0;
    endtask

    task automatic do_read(input int a, input int boot_frames, input string rq);
        int idx, tg, n0, waited, nf, base;
        bit hit, r2;
        logic [7:0] d2;
        idx = (a >> 4) & 15; tg = a >> 8; base = a & ~15;
        hit = ref_v[idx] && ref_t[idx] == tg;
        n0 = fr_op.size(); waited = 0; r2 = 0; d2 = 0;
        @(negedge clk); req_addr = a[23:0]; req_rd = 1;
        do begin
            @(negedge clk); waited++;
            if (waited == 2) begin r2 = rsp_ready; d2 = rsp_rdata; end
        end while (!rsp_ready && waited < 20000);
        req_rd = 0;
        check(rsp_ready, rq, "read ready seen", int'(rsp_ready), 1);
        check(rsp_rdata == exp_rd(a), rq, "read data", int'(rsp_rdata), int'(exp_rd(a)));
        nf = fr_op.size() - n0;
        if (boot_frames > 0) begin
            // R1: boot frames precede everything
            check(fr_op[n0] == 8'h66 && fr_n[n0] == 1, "R1", "reset-enable frame", fr_op[n0], 8'h66);
            check(fr_op[n0+1] == 8'h99 && fr_n[n0+1] == 1, "R1", "reset frame", fr_op[n0+1], 8'h99);
        end
        if (hit) begin
            check(nf == 0, "R6", "hit frame count", nf, 0);
            check(waited == 3, "R6", "hit latency", waited, 3);
            check(r2 == 0 && d2 == exp_rd(a), "R6", "data before ready", int'(d2), int'(exp_rd(a)));
        end else begin
            check(nf == boot_frames + FILL_FRAMES, "R4", "fill frame count", nf, boot_frames + FILL_FRAMES);
            for (int f = 0; f < FILL_FRAMES; f++) begin
                int k;
                k = n0 + boot_frames + f;
                if (k < fr_op.size()) begin
                    check(fr_op[k] == 8'h0B, "R3", "fill opcode", fr_op[k], 8'h0B);
                    check(fr_addr[k] == base + 8 * f, "R3", "fill address", fr_addr[k], base + 8 * f);
                    check(fr_n[k] == FILL_LEN, "R4", "fill frame bytes", fr_n[k], FILL_LEN);
                end
            end
            ref_v[idx] = 1; ref_t[idx] = tg;
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input string rq);
        int n0, waited, nf;
        n0 = fr_op.size(); waited = 0;
        exp_mem[a] = d;
        @(negedge clk); req_addr = a[23:0]; req_wdata = d; req_wr = 1;
        do begin @(negedge clk); waited++; end while (!rsp_ready && waited < 20000);
        req_wr = 0;
        nf = fr_op.size() - n0;
        check(rsp_ready && nf == 1, rq, "write frame count", nf, 1);
        if (nf >= 1) begin
            check(fr_op[n0] == 8'h02 && fr_n[n0] == 5, "R9", "write frame shape", fr_n[n0], 5);
            check(fr_addr[n0] == a, "R9", "write address", fr_addr[n0], a);
        end
        check(dev_rd(a) == d, "R9", "device byte", int'(dev_rd(a)), int'(d));
    endtask

    initial begin
        logic [7:0] held;
        ref_clear();
        // reset state
        repeat (3) @(negedge clk);
        check(cs_n == 1 && sck == 0, "R2", "idle pins in reset", int'({cs_n, sck}), 2);
        check(rsp_ready == 0, "R1", "ready low in reset", int'(rsp_ready), 0);
        rst_n = 1;
        // R1 + R7: first request waits for boot, then misses
        do_read(32'h000123, 2, "R7");
        // R6 / R7: hits over the whole line, both chunks
        do_read(32'h000123, 0, "R6");
        do_read(32'h000120, 0, "R7");
        do_read(32'h000127, 0, "R7");
        do_read(32'h000128, 0, "R7");
        do_read(32'h00012F, 0, "R7");
        // R11: data holds after the pulse
        held = rsp_rdata;
        repeat (6) @(negedge clk);
        check(rsp_rdata == held, "R11", "data held", int'(rsp_rdata), int'(held));
        // another line
        do_read(32'h012345, 0, "R7");
        do_read(32'h01234A, 0, "R6");
        // R8: aliasing on index 2
        do_read(32'h005127, 0, "R8");
        do_read(32'h000123, 0, "R8");
        do_read(32'h005127, 0, "R8");
        do_read(32'h000125, 0, "R8");
        // R5: last line of a page
        do_read(32'h0003F9, 0, "R5");
        do_read(32'h0007F0, 0, "R5");
        // R10: write to a resident line updates the cache
        do_write(32'h000125, 8'hA7, "R10");
        do_read(32'h000125, 0, "R10");
        // R10: write to an absent line does not allocate
        do_write(32'h070000, 8'h3C, "R10");
        do_read(32'h070000, 0, "R10");
        do_read(32'h070001, 0, "R10");
        // R12: reset clears valid bits
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        ref_clear();
        rst_n = 1;
        do_read(32'h000125, 2, "R12");
        do_read(32'h000125, 0, "R12");
        // R5: every fill frame inside one page
        for (int i = 0; i < fr_op.size(); i++) begin
            if (fr_op[i] == 8'h0B) begin
                int lo, hi;
                lo = fr_addr[i]; hi = fr_addr[i] + fr_n[i] - 6;
                check((lo >> 10) == (hi >> 10), "R5", "page crossing", hi, lo);
            end
        end
        check(cs_max <= CS_LIMIT, "R4", "select low cycles", cs_max, CS_LIMIT);
        check(cs_max == 1 + FILL_LEN * 17, "R4", "fill frame length", cs_max, 1 + FILL_LEN * 17);
        check(sck_bad == 0, "R2", "clock idle low", sck_bad, 0);
        check(mosi_bad == 0, "R2", "mosi steady while high", mosi_bad, 0);
        check(ready_bad == 0, "R11", "ready pulse width", ready_bad, 0);
        check(frame_ready_bad == 0, "R1", "ready during frame", frame_ready_bad, 0);
        finish_run();
    end

endmodule